// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a wide binary up-counter assembled from identical 4-bit slices. Every slice updates on the rising clock edge. Each slice has three controls, all taken at the edge: an active-low clear, an active-low parallel load, and a pair of count enables. One enable (`cnt_en`) goes to every slice at once. The other (`chain_en`) enters the lowest slice and also gates that slice's carry. Each higher slice takes its chain enable from the carry of the slice below, so a carry look-ahead path forms with no added gating. The carry of the top slice is brought out as the terminal-count flag `tc`. A downstream counter can use it as its own chain enable.

An optional modulus decoder compares the whole count with a programmed terminal value. On a match it pulls the internal clear low, so the counter goes back to zero on the next edge. The count length becomes `term_val + 1`. A parameter removes the decoder entirely. A run-time input turns the decode on or off.

Top module: `cnt_chain`

## Requirements
- R1: When `clr_n` is low at a rising edge, `count` becomes 0 after that edge, whatever the levels of `ld_n`, `cnt_en` and `chain_en` (clear has priority over load).
- R2: When `clr_n` is high, `ld_n` is low and no modulus match is present, `count` takes the value of `ld_data` after the edge, whatever the enables.
- R3: With `clr_n` and `ld_n` high, both enables high and no modulus match, `count` increases by one at each edge. The all-ones value wraps to 0.
- R4: With `clr_n` and `ld_n` high and no modulus match, `count` holds its value if either `cnt_en` or `chain_en` is low.
- R5: `tc` is high exactly when `chain_en` is high and every bit of `count` is 1. It is low in every other case.
- R6: A slice advances only when every slice below it reads 15 (4'b1111) and both enables are high. The counter therefore counts in plain binary across slice boundaries, e.g. 0x0FF steps to 0x100.
- R7: When `wrap_en` is high and `count` equals `term_val`, `count` becomes 0 after the next edge. This happens whatever the enables are, and it also overrides a load.
- R8: When `wrap_en` is low, `term_val` has no effect: a count equal to `term_val` keeps advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable sent to every slice |
| chain_en | input | 1 | Count enable into the lowest slice; also gates the carry |
| ld_data | input | STAGES*4 | Value loaded when `ld_n` is low |
| wrap_en | input | 1 | Turns on the modulus decode |
| term_val | input | STAGES*4 | Last count value before the return to 0 |
| count | output | STAGES*4 | Counter value |
| tc | output | 1 | Carry out of the top slice |

## Verification
The assertions start only once a clear has been seen, because the count is undefined until the first clear. They assume every control input is a known 0 or 1 at each rising edge. The bench keeps to this by applying a clear first. It drives all inputs on the falling edge, half a period away from the edge that samples them. The modulus decode compares combinationally against `term_val`. For that reason the assertions treat a match as an override of load, step and hold, and the stimulus changes `term_val` only on falling edges.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   localparam int SLICE_W = 4;

   typedef enum logic [1:0] {
      OP_CLEAR = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STEP  = 2'd2,
      OP_HOLD  = 2'd3
   } slice_op_e;

   // priority: clear, then load, then count, else hold
   function automatic slice_op_e pick_op(input logic clr_n,
                                         input logic ld_n,
                                         input logic en_a,
                                         input logic en_b);
      if (!clr_n)           return OP_CLEAR;
      else if (!ld_n)       return OP_LOAD;
      else if (en_a && en_b) return OP_STEP;
      else                  return OP_HOLD;
   endfunction

endpackage

// File: rtl/cnt_slice.sv
module cnt_slice
   import cnt_pkg::*;
#(
   parameter int SW = SLICE_W
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          ld_n,
   input  logic          cnt_en,
   input  logic          chain_in,
   input  logic [SW-1:0] d,
   output logic [SW-1:0] q,
   output logic          carry
);

   localparam logic [SW-1:0] TOP = '1;
   localparam logic [SW-1:0] ONE = SW'(1);

   slice_op_e op;

   if (SW < 1) begin : g_bad_width
      $error("cnt_slice: SW must be at least 1");
   end

   always_comb op = pick_op(clr_n, ld_n, cnt_en, chain_in);

   always_ff @(posedge clk) begin
      unique case (op)
         OP_CLEAR: q <= '0;
         OP_LOAD:  q <= d;
         OP_STEP:  q <= q + ONE;
         default:  q <= q;
      endcase
   end

   // look-ahead carry: only the chain enable gates it
   assign carry = chain_in & (q == TOP);

endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec #(
   parameter int W = 12
) (
   input  logic [W-1:0] value,
   input  logic [W-1:0] term,
   input  logic         wrap_en,
   input  logic         clr_in_n,
   output logic         clr_out_n
);

   logic match;

   if (W < 1) begin : g_bad_width
      $error("cnt_term_dec: W must be at least 1");
   end

   assign match     = wrap_en & (value == term);
   assign clr_out_n = clr_in_n & ~match;

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
   import cnt_pkg::*;
#(
   parameter int STAGES  = 3,
   parameter bit USE_MOD = 1'b1
) (
   input  logic                        clk,
   input  logic                        clr_n,
   input  logic                        ld_n,
   input  logic                        cnt_en,
   input  logic                        chain_en,
   input  logic [STAGES*SLICE_W-1:0]   ld_data,
   input  logic                        wrap_en,
   input  logic [STAGES*SLICE_W-1:0]   term_val,
   output logic [STAGES*SLICE_W-1:0]   count,
   output logic                        tc
);

   localparam int W = STAGES * SLICE_W;

   logic          clr_int_n;
   logic [STAGES:0] chain;

   if (STAGES < 1) begin : g_bad_stages
      $error("cnt_chain: STAGES must be at least 1");
   end

   if (USE_MOD) begin : g_mod
      cnt_term_dec #(.W(W)) u_dec (
         .value     (count),
         .term      (term_val),
         .wrap_en   (wrap_en),
         .clr_in_n  (clr_n),
         .clr_out_n (clr_int_n)
      );
   end else begin : g_no_mod
      assign clr_int_n = clr_n;
   end

   assign chain[0] = chain_en;

   for (genvar i = 0; i < STAGES; i++) begin : g_slice
      cnt_slice #(.SW(SLICE_W)) u_slice (
         .clk      (clk),
         .clr_n    (clr_int_n),
         .ld_n     (ld_n),
         .cnt_en   (cnt_en),
         .chain_in (chain[i]),
         .d        (ld_data[i*SLICE_W +: SLICE_W]),
         .q        (count[i*SLICE_W +: SLICE_W]),
         .carry    (chain[i+1])
      );
   end

   assign tc = chain[STAGES];

endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk
   import cnt_pkg::*;
#(
   parameter int STAGES  = 3,
   parameter bit USE_MOD = 1'b1
) (
   input logic                      clk,
   input logic                      clr_n,
   input logic                      ld_n,
   input logic                      cnt_en,
   input logic                      chain_en,
   input logic [STAGES*SLICE_W-1:0] ld_data,
   input logic                      wrap_en,
   input logic [STAGES*SLICE_W-1:0] term_val,
   input logic [STAGES*SLICE_W-1:0] count,
   input logic                      tc
);

   localparam int W = STAGES * SLICE_W;
   localparam logic [W-1:0] ONE = W'(1);

   logic primed = 1'b0;
   logic hit;

   always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

   assign hit = USE_MOD && wrap_en && (count == term_val);

   assert_clear_R1: assert property (@(posedge clk) disable iff (!primed)
      !clr_n |=> count == '0);

   assert_load_R2: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && !ld_n && !hit) |=> count == $past(ld_data));

   assert_step_R3: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && ld_n && cnt_en && chain_en && !hit) |=> count == $past(count) + ONE);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!primed)
      (clr_n && ld_n && !(cnt_en && chain_en) && !hit) |=> $stable(count));

   assert_carry_R5: assert property (@(posedge clk) disable iff (!primed)
      tc == (chain_en && (&count)));

   assert_modulus_R7: assert property (@(posedge clk) disable iff (!primed)
      hit |=> count == '0);

endmodule

bind cnt_chain cnt_chain_chk #(.STAGES(STAGES), .USE_MOD(USE_MOD)) u_chk (
   .clk      (clk),
   .clr_n    (clr_n),
   .ld_n     (ld_n),
   .cnt_en   (cnt_en),
   .chain_en (chain_en),
   .ld_data  (ld_data),
   .wrap_en  (wrap_en),
   .term_val (term_val),
   .count    (count),
   .tc       (tc)
);

// File: tb/cnt_chain_test.sv
`timescale 1ns/1ps
module cnt_chain_test;

   localparam int STAGES = 3;
   localparam int W = STAGES * 4;
   localparam logic [W-1:0] ALL1 = '1;
   localparam logic [W-1:0] ONE  = W'(1);

   logic         clk = 1'b0;
   logic         clr_n = 1'b1, ld_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0, wrap_en = 1'b0;
   logic [W-1:0] ld_data = '0, term_val = '0;
   logic [W-1:0] count;
   logic         tc;

   always #2 clk = ~clk;

   cnt_chain #(.STAGES(STAGES), .USE_MOD(1'b1)) uut (
      .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en), .chain_en(chain_en),
      .ld_data(ld_data), .wrap_en(wrap_en), .term_val(term_val),
      .count(count), .tc(tc)
   );

   int           n_vec = 0;
   int           n_bad = 0;
   logic [W-1:0] m_cnt = '0;
   bit           known = 1'b0;
   logic [W-1:0] exp_q[$];
   string        tag_q[$];

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // driver: applies one edge's worth of inputs and queues the expected count
   task automatic apply(input logic c, input logic l, input logic pe, input logic te,
                        input logic [W-1:0] d, input logic w, input logic [W-1:0] t,
                        input string tag);
      logic [W-1:0] nxt;
      @(negedge clk);
      clr_n = c; ld_n = l; cnt_en = pe; chain_en = te; ld_data = d; wrap_en = w; term_val = t;
      #0.5;
      if (known) check("R5 tc", {{(W-1){1'b0}}, tc}, {{(W-1){1'b0}}, te && (m_cnt == ALL1)});
      if (!c || (w && known && m_cnt == t)) nxt = '0;
      else if (!l)                          nxt = d;
      else if (pe && te)                    nxt = m_cnt + ONE;
      else                                  nxt = m_cnt;
      exp_q.push_back(nxt);
      tag_q.push_back(tag);
      m_cnt = nxt;
      known = 1'b1;
   endtask

   task automatic steps(input int n, input logic w, input logic [W-1:0] t, input string tag);
      for (int i = 0; i < n; i++) apply(1'b1, 1'b1, 1'b1, 1'b1, '0, w, t, tag);
   endtask

   // monitor: compares one cycle after each applying edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (tag_q.size() > 0) check(tag_q.pop_front(), count, exp_q.pop_front());
      end
   end

   initial begin
      #200000;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      // R1: clear wins over load and enables
      apply(1'b0, 1'b0, 1'b1, 1'b1, 12'hABC, 1'b0, '0, "R1 clear at start");
      steps(5, 1'b0, '0, "R3 count up");
      // R4: hold on either enable low
      for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, "R4 chain_en low");
      for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b0, 1'b1, '0, 1'b0, '0, "R4 cnt_en low");
      // R2 load then R6 slice crossing
      apply(1'b1, 1'b0, 1'b0, 1'b0, 12'h0FD, 1'b0, '0, "R2 load idle");
      steps(3, 1'b0, '0, "R6 cross 0FF");
      apply(1'b1, 1'b0, 1'b1, 1'b1, 12'h00E, 1'b0, '0, "R2 load");
      steps(3, 1'b0, '0, "R6 cross 00F");
      // R5 and R3 wrap
      apply(1'b1, 1'b0, 1'b1, 1'b1, 12'hFFE, 1'b0, '0, "R2 load near top");
      apply(1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0, '0, "R3 to all ones");
      apply(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, "R5 tc low when chain_en low");
      apply(1'b1, 1'b1, 1'b0, 1'b1, '0, 1'b0, '0, "R5 tc high hold");
      steps(2, 1'b0, '0, "R3 wrap to zero");
      apply(1'b1, 1'b0, 1'b1, 1'b1, 12'h123, 1'b0, '0, "R2 load while counting");
      apply(1'b0, 1'b0, 1'b1, 1'b1, 12'h456, 1'b0, '0, "R1 clear beats load");
      // R7 modulo-6 on the 3-slice chain
      steps(13, 1'b1, 12'h005, "R7 modulus wrap");
      apply(1'b1, 1'b0, 1'b1, 1'b1, 12'h005, 1'b1, 12'h005, "R7 load to term");
      apply(1'b1, 1'b0, 1'b1, 1'b1, 12'h077, 1'b1, 12'h005, "R7 clear beats load");
      apply(1'b1, 1'b0, 1'b1, 1'b1, 12'h005, 1'b1, 12'h005, "R7 load to term");
      apply(1'b1, 1'b1, 1'b0, 1'b0, '0, 1'b1, 12'h005, "R7 clear while disabled");
      // R8: decode off
      apply(1'b1, 1'b0, 1'b1, 1'b1, 12'h004, 1'b0, 12'h005, "R8 load");
      steps(4, 1'b0, 12'h005, "R8 decode off");
      // mixed stimulus
      for (int i = 0; i < 400; i++) begin
         apply(($urandom % 16) != 0, ($urandom % 8) != 0, ($urandom % 4) != 0,
               ($urandom % 4) != 0, W'($urandom), $urandom % 2, W'($urandom % 40),
               "R3 mixed");
      end
      repeat (3) @(posedge clk);
      #2;
      summary();
      $finish;
   end

endmodule